// File: doc/BRIEF.md
# SECDED Codec for 32-bit Words

This block protects a 32-bit word with a single-error-correcting, double-error-detecting code. It has two halves that share no state and are both purely combinational. The encoder turns 32 data bits into a 39-bit codeword: six Hamming check bits, the 32 data bits, and one parity bit over all of them. The decoder takes a 39-bit word that may have been damaged, returns the 32 data bits with any single flipped bit repaired, and gives a 2-bit status.

The status has four values. It separates a clean word, a fault confined to the overall parity bit, a corrected single error, and an uncorrectable error. A fault in the parity bit alone is reported as its own category because the data bits in that case were never at risk. The two halves are usually placed on either side of a storage element or a serial link, and the status goes to whatever logs or retries errors.

Top module: `secded32_codec`

## Requirements
- R1: Codeword bit `code[p-1]` holds Hamming position p, for p = 1..38. The check bits sit at positions 1, 2, 4, 8, 16 and 32. The data bits fill the remaining positions in ascending order, so `data[0]` is at position 3 and `data[31]` is at position 38. Each check bit at position 2^i makes the XOR of all positions whose index has bit i set equal to zero.
- R2: `code[38]` is the overall parity bit. It makes the XOR of all 39 codeword bits equal to zero.
- R3: A decoder input equal to a valid codeword gives status 00 and the encoded data.
- R4: A decoder input with exactly one of `code[37:0]` inverted gives the original data and status 11.
- R5: A decoder input with only `code[38]` inverted gives the original data and status 01.
- R6: A decoder input with any two codeword bits inverted gives status 10.
- R7: A decoder input whose syndrome is in the range 39..63 and whose overall parity is odd gives status 10. For example, inverting positions 2, 4 and 33 produces such an input.
- R8: Inverting only codeword bit index 5 of a valid codeword gives the original data and status 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data | input | 32 | Data word to encode |
| enc_code | output | 39 | Codeword produced for `enc_data` |
| dec_code | input | 39 | Possibly damaged codeword to decode |
| dec_data | output | 32 | Data after correction |
| dec_status | output | 2 | 00 clean, 01 parity bit only, 10 uncorrectable, 11 corrected |

## Verification
The hardest case to reach is a syndrome that points past position 38 while the overall parity is odd. No single or double error can produce it: it takes at least three flips chosen so that their positions XOR to 39 or more. The bench builds this case on purpose by inverting positions 2, 4 and 33 of valid codewords. It also sweeps every single-bit flip and every two-bit flip pair, so each syndrome value that a real single error can produce is covered.

// File: rtl/secded32_codec.sv
module secded32_codec (
  input  logic [31:0] enc_data,
  output logic [38:0] enc_code,
  input  logic [38:0] dec_code,
  output logic [31:0] dec_data,
  output logic [1:0]  dec_status
);
  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int HAM_W  = DATA_W + CHK_W;
  localparam int CODE_W = HAM_W + 1;

  logic [HAM_W:1] ham_e;
  logic [HAM_W:1] ham_d;
  logic [CHK_W-1:0] syn;
  logic             par_odd;
  logic             single_ok;

  always_comb begin
    int k;
    logic b;
    ham_e = '0;
    k = 0;
    for (int p = 1; p <= HAM_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        ham_e[p] = enc_data[k];
        k++;
      end
    end
    for (int i = 0; i < CHK_W; i++) begin
      b = 1'b0;
      for (int p = 1; p <= HAM_W; p++)
        if (p[i] && ((p & (p - 1)) != 0)) b = b ^ ham_e[p];
      ham_e[1 << i] = b;
    end
  end

  assign enc_code = {^ham_e, ham_e};

  always_comb begin
    syn = '0;
    for (int p = 1; p <= HAM_W; p++)
      if (dec_code[p-1]) syn = syn ^ p[CHK_W-1:0];
  end

  assign par_odd   = ^dec_code;
  assign single_ok = par_odd && (syn != '0) && (int'(syn) <= HAM_W);

  always_comb begin
    int k;
    ham_d = dec_code[HAM_W-1:0];
    for (int p = 1; p <= HAM_W; p++)
      if (single_ok && (int'(syn) == p)) ham_d[p] = ~ham_d[p];
    dec_data = '0;
    k = 0;
    for (int p = 1; p <= HAM_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        dec_data[k] = ham_d[p];
        k++;
      end
    end
  end

  always_comb begin
    if (syn == '0)
      dec_status = par_odd ? 2'b01 : 2'b00;
    else if (single_ok)
      dec_status = 2'b11;
    else
      dec_status = 2'b10;
  end

  always_comb begin
    if (!$isunknown(enc_data)) begin
      // R2
      enc_even_chk: assert (^enc_code == 1'b0);
    end
    if (!$isunknown({enc_data, dec_code})) begin
      // R3
      roundtrip_chk: assert ((dec_code != enc_code) || (dec_status == 2'b00 && dec_data == enc_data));
    end
    if (!$isunknown(dec_code)) begin
      // R6
      even_par_status_chk: assert ((^dec_code) || (dec_status == 2'b00 || dec_status == 2'b10));
      // R4
      odd_par_status_chk: assert (!(^dec_code) || (dec_status != 2'b00));
    end
  end

endmodule

// File: tb/secded32_codec_tb.sv
module secded32_codec_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] enc_data;
  logic [38:0] enc_code;
  logic [38:0] dec_code;
  logic [31:0] dec_data;
  logic [1:0]  dec_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  secded32_codec u_dut (
    .enc_data(enc_data), .enc_code(enc_code),
    .dec_code(dec_code), .dec_data(dec_data), .dec_status(dec_status)
  );

  function automatic logic [38:0] golden(input logic [31:0] d);
    logic [38:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= 38; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
        c[p-1] = d[k];
        k++;
      end
    for (int i = 0; i < 6; i++) begin
      logic s;
      s = 1'b0;
      for (int p = 1; p <= 38; p++)
        if ((p >> i) % 2 == 1 && p != (1 << i)) s ^= c[p-1];
      c[(1 << i) - 1] = s;
    end
    c[38] = ^c[37:0];
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic [38:0] flip);
    enc_data = d;
    @(posedge clk);
    dec_code = golden(d) ^ flip;
    @(negedge clk);
  endtask

  logic [31:0] pats [8];

  initial begin
    logic [31:0] lf;
    enc_data = '0;
    dec_code = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 reset", {dec_data, dec_status}, {32'h0, 2'b00});
    chk("R1 reset", enc_code, 39'h0);

    pats[0] = 32'h0; pats[1] = 32'hffffffff; pats[2] = 32'h01234567;
    pats[3] = 32'ha5a5a5a5; pats[4] = 32'h80000001;
    lf = 32'hace1ace1;
    for (int i = 5; i < 8; i++) begin
      lf = lf * 32'd1664525 + 32'd1013904223;
      pats[i] = lf;
    end

    for (int n = 0; n < 8; n++) begin
      apply(pats[n], '0);
      chk("R1 encode", enc_code, golden(pats[n]));
      chk("R2 parity", ^enc_code, 0);
      chk("R3 clean", {dec_data, dec_status}, {pats[n], 2'b00});
      for (int b = 0; b < 38; b++) begin
        apply(pats[n], 39'd1 << b);
        chk("R4 single", {dec_data, dec_status}, {pats[n], 2'b11});
      end
      apply(pats[n], 39'd1 << 38);
      chk("R5 parity only", {dec_data, dec_status}, {pats[n], 2'b01});
      apply(pats[n], 39'd1 << 5);
      chk("R8 bit5", {dec_data, dec_status}, {pats[n], 2'b11});
      apply(pats[n], (39'd1 << 1) | (39'd1 << 3) | (39'd1 << 32));
      chk("R7 beyond", dec_status, 2'b10);
    end

    for (int n = 2; n < 4; n++)
      for (int a = 0; a < 39; a++)
        for (int b = a + 1; b < 39; b++) begin
          apply(pats[n], (39'd1 << a) | (39'd1 << b));
          chk("R6 double", dec_status, 2'b10);
        end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule